// File: doc/BRIEF.md
# I2C Block-Addressed Memory Target

This block is an I2C target that presents a host with a memory split into 16-byte blocks. It watches the bus clock and data lines, answers to one fixed 7-bit device address, and moves one whole block per transaction. A host selects a block with a single index byte sent in a write transaction. Sixteen data bytes may follow in the same transaction to fill the block. To read, the host first sends a write transaction that carries only the index byte. It then opens a new transaction with the read bit set and clocks out sixteen bytes.

Index bytes are accepted only inside two separate windows. The main window runs from 00h to 3Ah with the default parameter, or to 7Ah when the large map is selected. The buffer window covers F8h to FBh. Any other index is refused with a NACK. The selected block stays selected across transactions until a new valid index arrives. Incoming data is first collected in a staging register. It is copied into the block store only when all sixteen bytes have arrived and a STOP ends the frame. The data line is driven only as an active-low pull enable, and the clock line is never driven.

Top module: `i2c_block_target`

## Requirements
- R1: Out of reset the data pull is off. It stays off whenever the target is idle between frames.
- R2: After a START the target ACKs a first byte whose upper seven bits equal TARGET_ADDR, with bit 0 as the read flag (1 = read). On a mismatch it never pulls the data line for the rest of that frame.
- R3: In a write frame each of the first 16 data bytes after an accepted index is ACKed. D0 goes to byte 0 of the block and D15 to byte 15, and the block is updated when the STOP arrives.
- R4: In a read frame the target shifts out bytes 0 through 15 of the selected block, MSB first. It changes the data line only while the clock is low.
- R5: The block selected by the last accepted index byte stays selected across later frames, so repeated reads return the same block.
- R6: With the default map, index bytes 00h–3Ah and F8h–FBh are ACKed and every other value is NACKed.
- R7: A refused index byte leaves the selected block unchanged. The data bytes that follow in that frame are not ACKed and change no block.
- R8: A write frame that ends, by STOP or by a repeated START, before 16 data bytes have been ACKed leaves the block unchanged.
- R9: A 17th data byte in a write frame is NACKed. The 16 bytes before it are still written at STOP.
- R10: If the host NACKs a byte during a read, the target stops sending and keeps the data pull off until the next START.
- R11: A START or a STOP anywhere, even in the middle of a byte, aborts the frame and returns the target to waiting for a device address.
- R12: The four buffer blocks F8h–FBh are storage separate from every main block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The bench targets the window edges 3Ah/3Bh and F7h/F8h/FBh/FCh. A faulty range check would either ACK a stray index and move the pointer, or refuse a legal block. Frames are cut short after eight bytes, after sixteen bytes followed by a repeated START, and in the middle of a byte. A design that commits too early or fails to abort on START/STOP would corrupt a block that should have stayed intact. A host NACK in the middle of a read, and a frame addressed to a foreign device, both check that the data line stays released. A target that kept sending would show up as a pull-low while the bench clocks on. Random blocks written to both windows and read back twice cover stale pointers and buffer blocks aliased onto main ones.

// File: rtl/i2cblk_pkg.sv
package i2cblk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_IDX,
    ST_WDAT,
    ST_DEV_ACK,
    ST_IDX_ACK,
    ST_DAT_ACK,
    ST_TX,
    ST_HOST_ACK,
    ST_IGNORE
  } ctrl_state_e;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cblk_line_sync.sv
module i2cblk_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= 1'b1;
          sda_chain <= 1'b1;
        end else begin
          scl_chain <= scl_in;
          sda_chain <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_in};
          sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cblk_range.sv
module i2cblk_range #(
  parameter int MAIN_CNT = 59,
  parameter int BUF_BASE = 248,
  parameter int BUF_CNT  = 4,
  parameter int SLOT_W   = 6
) (
  input  logic [7:0]        idx_byte,
  output logic              idx_ok,
  output logic [SLOT_W-1:0] idx_slot
);

  localparam int BUF_LAST = BUF_BASE + BUF_CNT - 1;

  logic in_main;
  logic in_buf;
  int   raw;

  always_comb begin
    raw      = int'(idx_byte);
    in_main  = raw < MAIN_CNT;
    in_buf   = (raw >= BUF_BASE) && (raw <= BUF_LAST);
    idx_ok   = in_main | in_buf;
    if (in_main) begin
      idx_slot = SLOT_W'(raw);
    end else if (in_buf) begin
      idx_slot = SLOT_W'(MAIN_CNT + raw - BUF_BASE);
    end else begin
      idx_slot = '0;
    end
  end

endmodule

// File: rtl/i2cblk_store.sv
module i2cblk_store #(
  parameter int NSLOT     = 63,
  parameter int BLK_BYTES = 16,
  parameter int SLOT_W    = 6,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              stage_we,
  input  logic [IDX_W-1:0]  stage_idx,
  input  logic [7:0]        stage_data,
  input  logic              commit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data
);

  localparam int BLK_BITS = BLK_BYTES * 8;

  logic [BLK_BITS-1:0] mem [NSLOT];
  logic [BLK_BITS-1:0] stage;
  logic [BLK_BITS-1:0] rd_blk;

  always_ff @(posedge clk) begin
    if (stage_we) begin
      stage[int'(stage_idx)*8 +: 8] <= stage_data;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      mem[slot] <= stage;
    end
  end

  always_comb begin
    rd_blk  = mem[slot];
    rd_data = rd_blk[int'(rd_idx)*8 +: 8];
  end

endmodule

// File: rtl/i2cblk_ctrl.sv
module i2cblk_ctrl
  import i2cblk_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h55,
  parameter int          BLK_BYTES  = 16,
  parameter int          SLOT_W     = 6,
  parameter int          IDX_W      = 4,
  parameter int          CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              idx_ok,
  input  logic [SLOT_W-1:0] idx_slot,
  input  logic [7:0]        rd_data,
  output logic [7:0]        rx_byte,
  output logic              stage_we,
  output logic [IDX_W-1:0]  stage_idx,
  output logic              commit,
  output logic [SLOT_W-1:0] ptr,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  bcnt,
  output ctrl_state_e       state,
  output logic              sda_pull
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BLK_BYTES);
  localparam logic [3:0]       LAST_BIT = 4'd7;
  localparam logic [3:0]       BYTE_END = 4'd8;

  ctrl_state_e       st_n;
  logic [3:0]        bit_q, bit_n;
  logic [7:0]        rx_q, rx_n;
  logic [7:0]        tx_q, tx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SLOT_W-1:0] ptr_n;
  logic              pull_n;
  logic              wmode_q, wmode_n;
  logic              rd_q, rd_n;
  logic              hack_q, hack_n;
  logic              byte_in;

  assign byte_in = scl_fall && (bit_q == BYTE_END);

  always_comb begin
    st_n     = state;
    bit_n    = bit_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    cnt_n    = cnt_q;
    ptr_n    = ptr;
    pull_n   = sda_pull;
    wmode_n  = wmode_q;
    rd_n     = rd_q;
    hack_n   = hack_q;
    stage_we = 1'b0;
    commit   = 1'b0;
    if (start_det) begin
      st_n    = ST_DEV;
      bit_n   = '0;
      cnt_n   = '0;
      pull_n  = 1'b0;
      wmode_n = 1'b0;
    end else if (stop_det) begin
      st_n    = ST_IDLE;
      pull_n  = 1'b0;
      commit  = wmode_q && (cnt_q == FULL);
      wmode_n = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_IDX, ST_WDAT: begin
          if (scl_rise && (bit_q < BYTE_END)) begin
            rx_n  = {rx_q[6:0], sda_s};
            bit_n = bit_q + 4'd1;
          end
          if (byte_in) begin
            bit_n = '0;
            if (state == ST_DEV) begin
              if (rx_q[7:1] == TARGET_ADDR) begin
                pull_n = 1'b1;
                rd_n   = rx_q[0];
                cnt_n  = '0;
                st_n   = ST_DEV_ACK;
              end else begin
                st_n = ST_IGNORE;
              end
            end else if (state == ST_IDX) begin
              if (idx_ok) begin
                pull_n  = 1'b1;
                ptr_n   = idx_slot;
                wmode_n = 1'b1;
                cnt_n   = '0;
                st_n    = ST_IDX_ACK;
              end else begin
                st_n = ST_IGNORE;
              end
            end else begin
              if (cnt_q < FULL) begin
                pull_n   = 1'b1;
                stage_we = 1'b1;
                cnt_n    = cnt_q + 1'b1;
                st_n     = ST_DAT_ACK;
              end else begin
                st_n = ST_IGNORE;
              end
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rd_q) begin
              tx_n   = rd_data;
              pull_n = ~rd_data[7];
              cnt_n  = cnt_q + 1'b1;
              st_n   = ST_TX;
            end else begin
              pull_n = 1'b0;
              st_n   = ST_IDX;
            end
          end
        end
        ST_IDX_ACK, ST_DAT_ACK: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            st_n   = ST_WDAT;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              pull_n = 1'b0;
              st_n   = ST_HOST_ACK;
            end else begin
              tx_n   = {tx_q[6:0], 1'b0};
              pull_n = ~tx_q[6];
              bit_n  = bit_q + 4'd1;
            end
          end
        end
        ST_HOST_ACK: begin
          if (scl_rise) begin
            hack_n = ~sda_s;
          end
          if (scl_fall) begin
            if (hack_q && (cnt_q < FULL)) begin
              tx_n   = rd_data;
              pull_n = ~rd_data[7];
              cnt_n  = cnt_q + 1'b1;
              bit_n  = '0;
              st_n   = ST_TX;
            end else begin
              st_n = ST_IGNORE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wmode_q  <= 1'b0;
      rd_q     <= 1'b0;
      hack_q   <= 1'b0;
    end else begin
      state    <= st_n;
      bit_q    <= bit_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      cnt_q    <= cnt_n;
      ptr      <= ptr_n;
      sda_pull <= pull_n;
      wmode_q  <= wmode_n;
      rd_q     <= rd_n;
      hack_q   <= hack_n;
    end
  end

  assign rx_byte   = rx_q;
  assign stage_idx = cnt_q[IDX_W-1:0];
  assign rd_idx    = cnt_q[IDX_W-1:0];
  assign bcnt      = cnt_q;

endmodule

// File: rtl/i2c_block_target.sv
module i2c_block_target
  import i2cblk_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h55,
  parameter bit          LARGE_MAP  = 1'b0,
  parameter int          BLK_BYTES  = 16,
  parameter int          BUF_BASE   = 248,
  parameter int          BUF_CNT    = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull_o
);

  localparam int MAIN_CNT = LARGE_MAP ? 123 : 59;
  localparam int NSLOT    = MAIN_CNT + BUF_CNT;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int IDX_W    = $clog2(BLK_BYTES);
  localparam int CNT_W    = IDX_W + 1;

  logic              rst_meta;
  logic              rst_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              idx_ok;
  logic [SLOT_W-1:0] idx_slot;
  logic [7:0]        rx_byte;
  logic              stage_we;
  logic [IDX_W-1:0]  stage_idx;
  logic              commit;
  logic [SLOT_W-1:0] ptr;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        rd_data;
  logic [CNT_W-1:0]  bcnt;
  ctrl_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  i2cblk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cblk_range #(
    .MAIN_CNT(MAIN_CNT), .BUF_BASE(BUF_BASE), .BUF_CNT(BUF_CNT), .SLOT_W(SLOT_W)
  ) u_range (
    .idx_byte(rx_byte), .idx_ok(idx_ok), .idx_slot(idx_slot)
  );

  i2cblk_ctrl #(
    .TARGET_ADDR(TARGET_ADDR), .BLK_BYTES(BLK_BYTES), .SLOT_W(SLOT_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .idx_ok(idx_ok), .idx_slot(idx_slot), .rd_data(rd_data),
    .rx_byte(rx_byte), .stage_we(stage_we), .stage_idx(stage_idx),
    .commit(commit), .ptr(ptr), .rd_idx(rd_idx), .bcnt(bcnt),
    .state(state), .sda_pull(sda_pull_o)
  );

  i2cblk_store #(
    .NSLOT(NSLOT), .BLK_BYTES(BLK_BYTES), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .stage_we(stage_we), .stage_idx(stage_idx),
    .stage_data(rx_byte), .commit(commit), .slot(ptr),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

endmodule

// File: rtl/i2c_block_target_chk.sv
module i2c_block_target_chk
  import i2cblk_pkg::*;
#(
  parameter int NSLOT  = 63,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_pull,
  input logic              start_det,
  input logic              stop_det,
  input logic              idx_ok,
  input logic [SLOT_W-1:0] ptr,
  input ctrl_state_e       state
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull) else $error("idle pull"); // R1

  AST_PULL_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s) else $error("pull while clock high"); // R4

  AST_PTR_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(idx_ok)) else $error("pointer moved"); // R7

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NSLOT) else $error("pointer range"); // R6

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE)) else $error("stop abort"); // R11

  AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV)) else $error("start abort"); // R11

endmodule

bind i2c_block_target i2c_block_target_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .start_det(start_det), .stop_det(stop_det), .idx_ok(idx_ok),
  .ptr(ptr), .state(state)
);

// File: tb/i2c_block_target_test.sv
module i2c_block_target_test;

  localparam logic [6:0] TA = 7'h55;
  localparam int Q = 5;

  logic clk;
  logic rst_n;
  logic scl_h;
  logic sda_h;
  logic sda_pull;
  logic sda_line;

  int n_chk;
  int n_bad;
  bit done;
  bit watch_en;
  bit pull_seen;

  logic [127:0] ref_mem [256];
  bit           ref_known [256];
  int           ref_ptr;

  assign sda_line = sda_h & ~sda_pull;

  i2c_block_target #(.TARGET_ADDR(TA)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
    .sda_pull_o(sda_pull)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (watch_en && sda_pull) pull_seen = 1'b1;
  end

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [7:0] a);
    return (a <= 8'h3A) || (a >= 8'hF8 && a <= 8'hFB);
  endfunction

  function automatic logic [7:0] rand_valid();
    int r;
    r = $urandom % 63;
    return (r < 59) ? 8'(r) : 8'(248 + r - 59);
  endfunction

  function automatic logic [127:0] rand_blk();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; tq(); scl_h = 1'b1; tq(); sda_h = 1'b0; tq(); scl_h = 1'b0; tq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tq(); scl_h = 1'b1; tq(); sda_h = 1'b1; tq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_h = b[7-i]; tq(); scl_h = 1'b1; tq(); scl_h = 1'b0; tq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_h = 1'b1; tq(); scl_h = 1'b1; tq();
    acked = (sda_line == 1'b0);
    scl_h = 1'b0; tq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq(); scl_h = 1'b1; tq(); b[i] = sda_line; scl_h = 1'b0;
    end
    tq(); sda_h = give_ack ? 1'b0 : 1'b1;
    tq(); scl_h = 1'b1; tq(); scl_h = 1'b0; tq(); sda_h = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] blk, input logic [127:0] d,
                          input int nbytes, input logic [7:0] extra,
                          input bit end_stop, output bit a_ack,
                          output bit b_ack, output int n_ack);
    bit k;
    bus_start();
    send_byte({TA, 1'b0}, a_ack);
    send_byte(blk, b_ack);
    n_ack = 0;
    for (int i = 0; i < nbytes; i++) begin
      send_byte((i < 16) ? d[i*8 +: 8] : extra, k);
      if (k) n_ack++;
    end
    if (end_stop) bus_stop();
    if (in_win(blk)) ref_ptr = int'(blk);
    if (end_stop && in_win(blk) && nbytes >= 16) begin
      ref_mem[blk] = d;
      ref_known[blk] = 1'b1;
    end
  endtask

  task automatic rd_frame(output logic [127:0] d, output bit a_ack);
    logic [7:0] b;
    bus_start();
    send_byte({TA, 1'b1}, a_ack);
    for (int i = 0; i < 16; i++) begin
      recv_byte(1'b1, b);
      d[i*8 +: 8] = b;
    end
    bus_stop();
  endtask

  task automatic rd_check(input string req);
    logic [127:0] d;
    bit a;
    rd_frame(d, a);
    chk(a, req, 128'(a), 128'd1);
    chk(d === ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
  endtask

  task automatic wr_check(input logic [7:0] blk, input string req);
    bit a, b;
    int n;
    wr_frame(blk, rand_blk(), 16, 8'h00, 1'b1, a, b, n);
    chk(a && b && n == 16, req, 128'(n), 128'd16);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    logic [7:0] b;
    bit a, ak, bk;
    int n;
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; done = 1'b0;
    watch_en = 1'b0; pull_seen = 1'b0;
    ref_ptr = 0;
    for (int i = 0; i < 256; i++) ref_known[i] = 1'b0;
    scl_h = 1'b1; sda_h = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released after reset
    chk(!sda_pull, "R1", 128'(sda_pull), 128'd0);

    // R2: foreign device address never pulled
    pull_seen = 1'b0; watch_en = 1'b1;
    bus_start();
    send_byte({7'h2A, 1'b0}, a);
    send_byte(8'h00, bk);
    send_byte(8'hA5, bk);
    bus_stop();
    watch_en = 1'b0;
    chk(!pull_seen && !a, "R2", 128'(pull_seen), 128'd0);
    repeat (3) @(negedge clk);
    chk(!sda_pull, "R1", 128'(sda_pull), 128'd0);

    // R3/R6/R12: window edges, written and read back
    wr_check(8'h00, "R3"); rd_check("R4");
    wr_check(8'h3A, "R6"); rd_check("R4");
    wr_check(8'hF8, "R12"); rd_check("R12");
    wr_check(8'hFB, "R6"); rd_check("R12");
    ref_ptr = 0;
    wr_frame(8'h00, 128'd0, 0, 8'h00, 1'b1, a, bk, n);
    rd_check("R12");

    // R5: random blocks, read twice
    for (int it = 0; it < 6; it++) begin
      wr_check(rand_valid(), "R3");
      rd_check("R5");
      rd_check("R5");
    end

    // R6/R7: out-of-window index bytes refused, pointer kept
    begin
      logic [7:0] bad [5];
      bad[0] = 8'h3B; bad[1] = 8'h7F; bad[2] = 8'hF7; bad[3] = 8'hFC; bad[4] = 8'hFF;
      for (int i = 0; i < 5; i++) begin
        wr_frame(bad[i], 128'd0, 0, 8'h00, 1'b1, a, bk, n);
        chk(a && !bk, "R6", 128'(bk), 128'd0);
      end
    end
    rd_check("R7");
    wr_frame(8'h40, rand_blk(), 16, 8'h00, 1'b1, a, bk, n);
    chk(n == 0, "R7", 128'(n), 128'd0);
    rd_check("R7");

    // R8: short write and repeated start before stop
    wr_frame(8'h3A, 128'd0, 0, 8'h00, 1'b1, a, bk, n);
    wr_frame(8'h3A, rand_blk(), 8, 8'h00, 1'b1, a, bk, n);
    rd_check("R8");
    wr_frame(8'h3A, rand_blk(), 16, 8'h00, 1'b0, a, bk, n);
    rd_check("R8");

    // R9: 17th byte refused, 16 still stored
    wr_frame(8'hF9, rand_blk(), 17, 8'h5A, 1'b1, a, bk, n);
    chk(n == 16, "R9", 128'(n), 128'd16);
    rd_check("R9");

    // R10: host NACK ends the read
    bus_start();
    send_byte({TA, 1'b1}, a);
    for (int i = 0; i < 3; i++) begin
      recv_byte(1'b1, b);
      chk(b === ref_mem[ref_ptr][i*8 +: 8], "R4", 128'(b), 128'(ref_mem[ref_ptr][i*8 +: 8]));
    end
    recv_byte(1'b0, b);
    pull_seen = 1'b0; watch_en = 1'b1;
    recv_byte(1'b1, b);
    recv_byte(1'b1, b);
    watch_en = 1'b0;
    bus_stop();
    chk(!pull_seen, "R10", 128'(pull_seen), 128'd0);
    rd_check("R10");

    // R11: start in mid-byte, then a clean write
    bus_start();
    send_byte({TA, 1'b0}, a);
    send_bits(8'hA0, 4);
    d = rand_blk();
    wr_frame(8'h21, d, 16, 8'h00, 1'b1, a, bk, n);
    chk(a && bk && n == 16, "R11", 128'(n), 128'd16);
    rd_check("R11");
    // R11: stop in mid-byte of data leaves block intact
    bus_start();
    send_byte({TA, 1'b0}, a);
    send_byte(8'h00, bk);
    ref_ptr = 0;
    send_bits(8'hFF, 5);
    bus_stop();
    rd_check("R11");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule